// File: doc/BRIEF.md
# DMA Channel Address Loop Engine

This block is the data-path sequencer of one DMA channel. Software loads a transfer descriptor through a one-cycle load strobe: a source and a destination address, a signed step for each side, an attribute byte per side (access size and circular-buffer modulo), a minor-loop word, signed end-of-major adjustments and an iteration start count. After that, each service request moves one minor loop. For every element the engine reads the source and then writes the destination on a single-outstanding request/acknowledge memory bus, and it steps both addresses after each access.

When a minor loop ends, the iteration counter counts down by one. A minor-loop offset can be added to either address at this point. When the counter runs out, the major loop is complete: the end adjustments are applied and the counter reloads. Completion and half-way points raise sticky flags, and these feed an interrupt line through per-descriptor enables. A request that arrives while a loop is running is remembered and served as soon as the engine returns to idle.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset, busy, done_flag, half_flag, irq and mem_req are low and cur_iter, cur_src_addr and cur_dst_addr are zero.
- R2: The size code is bits 2:0 of each attribute byte. Code 0 is 8-bit, code 1 is 16-bit, and codes 2 to 7 are 32-bit. mem_be selects the lanes at the address (8-bit: lane addr[1:0]; 16-bit: lanes from {addr[1],0}; 32-bit: all four). The read element is taken from its source lanes and zero-extended. It is written into the destination lanes.
- R3: A minor loop performs floor(count / source element bytes) read-write pairs, where count is the minor-loop byte count. Each pair reads first and then writes. A count below one element performs no access, but the loop still ends and counts down.
- R4: After each read, the sign-extended 16-bit source step is added to the source address. After each write, the destination step is added to the destination address. A step of 0 keeps the address fixed.
- R5: Attribute bits 7:3 hold a modulo M. When M is nonzero, the per-access step changes only address bits M-1:0, which gives a circular buffer of 2^M bytes. M = 0 gives a plain add.
- R6: At the end of each minor loop the iteration count decrements. When it was 1 (or 0), the major loop completes instead: the signed end adjustments are added to both addresses, the count reloads from the start count, and done_flag sets. Loading a descriptor sets the count to the start count.
- R7: With offset mode on, the minor-loop word is split into fields: bit 31 enables the source, bit 30 enables the destination, bits 29:10 hold a signed offset, and bits 9:0 hold the byte count. After a minor loop that does not complete the major loop, the offset is added to each enabled address. At major completion only the end adjustments apply. With offset mode off, all 32 bits are the byte count.
- R8: half_flag sets when a minor loop leaves the count equal to start/2 (integer division), provided this is not a major completion.
- R9: Both flags stay set until a flag_clr pulse clears them. A flag that sets in the same cycle as a clear stays set. irq = (done_flag and the major enable) or (half_flag and the half enable).
- R10: A service request that arrives while a loop is running, including in its last cycle, is held pending and starts a new minor loop once the engine is idle.
- R11: cfg_load is ignored while busy: the addresses and the count continue unchanged.
- R12: Only one bus access is outstanding. mem_req stays high with a stable address, direction and write data until mem_ack. mem_req is low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Descriptor load strobe (idle only) |
| cfg_src_addr | input | AW | Source start address |
| cfg_src_step | input | 16 | Signed source step per access |
| cfg_src_attr | input | 8 | Source modulo [7:3], size code [2:0] |
| cfg_dst_addr | input | AW | Destination start address |
| cfg_dst_step | input | 16 | Signed destination step per access |
| cfg_dst_attr | input | 8 | Destination modulo [7:3], size code [2:0] |
| cfg_minor_word | input | 32 | Minor-loop byte count, or offset-mode fields |
| cfg_loop_ofs_mode | input | 1 | Minor-loop offset mode enable |
| cfg_src_end_adj | input | AW | Signed source adjustment at major completion |
| cfg_dst_end_adj | input | AW | Signed destination adjustment at major completion |
| cfg_iter_start | input | CW | Iteration start count |
| cfg_half_irq_en | input | 1 | Half-way interrupt enable |
| cfg_end_irq_en | input | 1 | Major-completion interrupt enable |
| svc_req | input | 1 | Service request pulse (one minor loop) |
| flag_clr | input | 1 | Clear pulse for done and half flags |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_be | output | DW/8 | Byte lane enables |
| mem_wdata | output | DW | Write data, lane aligned |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Minor loop in progress |
| done_flag | output | 1 | Sticky major-completion flag |
| half_flag | output | 1 | Sticky half-way flag |
| irq | output | 1 | Enabled flag interrupt |
| cur_src_addr | output | AW | Current source address |
| cur_dst_addr | output | AW | Current destination address |
| cur_iter | output | CW | Current iteration count |

## Verification
Two pairs of events can land in the same cycle. In the completion cycle of a minor loop, the flag update can meet a flag_clr pulse, and the counter reload can meet a fresh service request. The bench raises the clear or the request on the falling edge right after the last write acknowledge, which places it in that completion cycle. A correct design then shows done_flag still set after a same-cycle clear, and runs the follow-on minor loop without a further request. Random descriptors add modulo wrap, mixed access sizes and minor-loop offsets on top of these cases, and every bus access is compared against a bench address model.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} dma_st_e;

   localparam int SMLOE_BIT  = 31;
   localparam int DMLOE_BIT  = 30;
   localparam int MLOFF_MSB  = 29;
   localparam int MLOFF_LSB  = 10;
   localparam int MLOFF_W    = MLOFF_MSB - MLOFF_LSB + 1;
   localparam int NB_SHORT_W = 10;
   localparam int STEP_W     = 16;

   // log2 of element bytes; codes above 2 behave as 32-bit
   function automatic logic [1:0] size_lg2(input logic [2:0] code);
      return (code >= 3'd2) ? 2'd2 : code[1:0];
   endfunction
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int AW     = 32,
   parameter bit MOD_EN = 1'b1
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] delta,
   input  logic [4:0]    modulo,
   output logic [AW-1:0] nxt
);
   logic [AW-1:0] sum;
   assign sum = base + delta;

   generate
      if (MOD_EN) begin : g_mod
         logic [AW-1:0] keep_mask;
         always_comb begin
            if (modulo == 5'd0) keep_mask = '1;
            else                keep_mask = (AW'(1) << modulo) - AW'(1);
         end
         assign nxt = (base & ~keep_mask) | (sum & keep_mask);
      end else begin : g_plain
         logic unused_modulo;
         assign unused_modulo = ^modulo;
         assign nxt = sum;
      end
   endgenerate
endmodule

// File: rtl/dma_lane_align.sv
module dma_lane_align #(
   parameter int DW = 32,
   localparam int BW = DW / 8
) (
   input  logic [1:0]    lo,
   input  logic [1:0]    lg2,
   input  logic [DW-1:0] wr_val,
   input  logic [DW-1:0] rd_bus,
   output logic [BW-1:0] be,
   output logic [DW-1:0] wr_bus,
   output logic [DW-1:0] rd_val
);
   logic [1:0]    sh;
   logic [BW-1:0] base_be;
   logic [DW-1:0] size_mask;

   always_comb begin
      case (lg2)
         2'd0: begin sh = lo;             base_be = BW'(1); size_mask = DW'(8'hFF);    end
         2'd1: begin sh = {lo[1], 1'b0}; base_be = BW'(3); size_mask = DW'(16'hFFFF); end
         default: begin sh = 2'd0;       base_be = '1;     size_mask = '1;            end
      endcase
      be     = base_be << sh;
      wr_bus = wr_val << {sh, 3'b000};
      rd_val = (rd_bus >> {sh, 3'b000}) & size_mask;
   end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
   import dma_loop_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter bit MODULO_EN = 1'b1,
   localparam int BW       = DW / 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_load,
   input  logic [AW-1:0] cfg_src_addr,
   input  logic [15:0]   cfg_src_step,
   input  logic [7:0]    cfg_src_attr,
   input  logic [AW-1:0] cfg_dst_addr,
   input  logic [15:0]   cfg_dst_step,
   input  logic [7:0]    cfg_dst_attr,
   input  logic [31:0]   cfg_minor_word,
   input  logic          cfg_loop_ofs_mode,
   input  logic [AW-1:0] cfg_src_end_adj,
   input  logic [AW-1:0] cfg_dst_end_adj,
   input  logic [CW-1:0] cfg_iter_start,
   input  logic          cfg_half_irq_en,
   input  logic          cfg_end_irq_en,
   input  logic          svc_req,
   input  logic          flag_clr,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [BW-1:0] mem_be,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          mem_ack,
   output logic          busy,
   output logic          done_flag,
   output logic          half_flag,
   output logic          irq,
   output logic [AW-1:0] cur_src_addr,
   output logic [AW-1:0] cur_dst_addr,
   output logic [CW-1:0] cur_iter
);
   generate
      if (DW != 32) begin : g_dw_chk
         $error("dma_loop_engine: DW must be 32");
      end
      if (AW < MLOFF_W || AW < STEP_W) begin : g_aw_chk
         $error("dma_loop_engine: AW too narrow for offsets");
      end
      if (CW < 2) begin : g_cw_chk
         $error("dma_loop_engine: CW must be at least 2");
      end
   endgenerate

   // descriptor state
   logic [AW-1:0] d_saddr, d_daddr, d_slast, d_dlast;
   logic [15:0]   d_sstep, d_dstep;
   logic [7:0]    d_sattr, d_dattr;
   logic [31:0]   d_minor;
   logic          d_mode, d_hen, d_een;
   logic [CW-1:0] d_citer, d_biter;

   // sequencer state
   dma_st_e       st;
   logic [31:0]   remain;
   logic [DW-1:0] hold;
   logic          pend, done_q, half_q;

   logic          start, major_end, done_set, half_set;
   logic [31:0]   byte_cnt, n_acc;
   logic [CW-1:0] iter_dec;
   logic [AW-1:0] s_step_x, d_step_x, ml_ofs, s_next, d_next;
   logic [DW-1:0] rd_val;
   logic [1:0]    lane_lg2;

   assign start     = (st == ST_IDLE) && (pend || svc_req);
   assign byte_cnt  = d_mode ? {{(32-NB_SHORT_W){1'b0}}, d_minor[NB_SHORT_W-1:0]} : d_minor;
   assign n_acc     = byte_cnt >> size_lg2(d_sattr[2:0]);
   assign s_step_x  = {{(AW-STEP_W){d_sstep[15]}}, d_sstep};
   assign d_step_x  = {{(AW-STEP_W){d_dstep[15]}}, d_dstep};
   assign ml_ofs    = {{(AW-MLOFF_W){d_minor[MLOFF_MSB]}}, d_minor[MLOFF_MSB:MLOFF_LSB]};
   assign major_end = (d_citer <= CW'(1));
   assign iter_dec  = d_citer - CW'(1);
   assign done_set  = (st == ST_FIN) && major_end;
   assign half_set  = (st == ST_FIN) && !major_end && (iter_dec == (d_biter >> 1));

   dma_addr_step #(.AW(AW), .MOD_EN(MODULO_EN)) u_src_step (
      .base(d_saddr), .delta(s_step_x), .modulo(d_sattr[7:3]), .nxt(s_next));
   dma_addr_step #(.AW(AW), .MOD_EN(MODULO_EN)) u_dst_step (
      .base(d_daddr), .delta(d_step_x), .modulo(d_dattr[7:3]), .nxt(d_next));

   assign mem_req  = (st == ST_RD) || (st == ST_WR);
   assign mem_we   = (st == ST_WR);
   assign mem_addr = mem_we ? d_daddr : d_saddr;
   assign lane_lg2 = mem_we ? size_lg2(d_dattr[2:0]) : size_lg2(d_sattr[2:0]);

   dma_lane_align #(.DW(DW)) u_lane (
      .lo(mem_addr[1:0]), .lg2(lane_lg2), .wr_val(hold), .rd_bus(mem_rdata),
      .be(mem_be), .wr_bus(mem_wdata), .rd_val(rd_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_saddr <= '0; d_daddr <= '0; d_slast <= '0; d_dlast <= '0;
         d_sstep <= '0; d_dstep <= '0; d_sattr <= '0; d_dattr <= '0;
         d_minor <= '0; d_mode  <= 1'b0; d_hen  <= 1'b0; d_een  <= 1'b0;
         d_citer <= '0; d_biter <= '0;
         st      <= ST_IDLE;
         remain  <= '0;
         hold    <= '0;
         pend    <= 1'b0;
         done_q  <= 1'b0;
         half_q  <= 1'b0;
      end else begin
         pend   <= start ? (pend && svc_req) : (pend || svc_req);
         done_q <= done_set || (done_q && !flag_clr);
         half_q <= half_set || (half_q && !flag_clr);

         case (st)
            ST_IDLE: begin
               if (cfg_load) begin
                  d_saddr <= cfg_src_addr;    d_daddr <= cfg_dst_addr;
                  d_slast <= cfg_src_end_adj; d_dlast <= cfg_dst_end_adj;
                  d_sstep <= cfg_src_step;    d_dstep <= cfg_dst_step;
                  d_sattr <= cfg_src_attr;    d_dattr <= cfg_dst_attr;
                  d_minor <= cfg_minor_word;  d_mode  <= cfg_loop_ofs_mode;
                  d_hen   <= cfg_half_irq_en; d_een   <= cfg_end_irq_en;
                  d_biter <= cfg_iter_start;  d_citer <= cfg_iter_start;
               end
               if (start) begin
                  remain <= n_acc;
                  st     <= (n_acc == 32'd0) ? ST_FIN : ST_RD;
               end
            end
            ST_RD: begin
               if (mem_ack) begin
                  hold    <= rd_val;
                  d_saddr <= s_next;
                  st      <= ST_WR;
               end
            end
            ST_WR: begin
               if (mem_ack) begin
                  d_daddr <= d_next;
                  remain  <= remain - 32'd1;
                  st      <= (remain == 32'd1) ? ST_FIN : ST_RD;
               end
            end
            default: begin
               if (major_end) begin
                  d_saddr <= d_saddr + d_slast;
                  d_daddr <= d_daddr + d_dlast;
                  d_citer <= d_biter;
               end else begin
                  d_citer <= iter_dec;
                  if (d_mode && d_minor[SMLOE_BIT]) d_saddr <= d_saddr + ml_ofs;
                  if (d_mode && d_minor[DMLOE_BIT]) d_daddr <= d_daddr + ml_ofs;
               end
               st <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy         = (st != ST_IDLE);
   assign done_flag    = done_q;
   assign half_flag    = half_q;
   assign irq          = (done_q && d_een) || (half_q && d_hen);
   assign cur_src_addr = d_saddr;
   assign cur_dst_addr = d_daddr;
   assign cur_iter     = d_citer;
endmodule

// File: rtl/dma_loop_checker.sv
module dma_loop_checker #(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_load,
   input logic          flag_clr,
   input logic          mem_req,
   input logic          mem_we,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic [DW/8-1:0] mem_be,
   input logic [DW-1:0] mem_wdata,
   input logic          busy,
   input logic          done_flag,
   input logic [AW-1:0] cur_dst_addr,
   input logic [CW-1:0] cur_iter
);
   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12

   AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && !mem_ack |=> $stable(mem_wdata)); // R12

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req); // R12

   AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == 4)); // R2

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_flag && !flag_clr |=> done_flag); // R9

   AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load && mem_req && !mem_ack |=> $stable(cur_dst_addr) && $stable(cur_iter)); // R11
endmodule

bind dma_loop_engine dma_loop_checker #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .flag_clr(flag_clr),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .mem_be(mem_be), .mem_wdata(mem_wdata), .busy(busy), .done_flag(done_flag),
   .cur_dst_addr(cur_dst_addr), .cur_iter(cur_iter));

// File: tb/dma_loop_engine_tb.sv
module dma_loop_engine_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int CW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_load = 1'b0, cfg_loop_ofs_mode = 1'b0, cfg_half_irq_en = 1'b0, cfg_end_irq_en = 1'b0;
   logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0, cfg_src_end_adj = '0, cfg_dst_end_adj = '0;
   logic [15:0] cfg_src_step = '0, cfg_dst_step = '0;
   logic [7:0] cfg_src_attr = '0, cfg_dst_attr = '0;
   logic [31:0] cfg_minor_word = '0;
   logic [CW-1:0] cfg_iter_start = '0;
   logic svc_req = 1'b0, flag_clr = 1'b0, mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic mem_req, mem_we, busy, done_flag, half_flag, irq;
   logic [AW-1:0] mem_addr, cur_src_addr, cur_dst_addr;
   logic [3:0] mem_be;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] cur_iter;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_loop_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src_addr(cfg_src_addr),
      .cfg_src_step(cfg_src_step), .cfg_src_attr(cfg_src_attr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_dst_step(cfg_dst_step), .cfg_dst_attr(cfg_dst_attr), .cfg_minor_word(cfg_minor_word),
      .cfg_loop_ofs_mode(cfg_loop_ofs_mode), .cfg_src_end_adj(cfg_src_end_adj),
      .cfg_dst_end_adj(cfg_dst_end_adj), .cfg_iter_start(cfg_iter_start),
      .cfg_half_irq_en(cfg_half_irq_en), .cfg_end_irq_en(cfg_end_irq_en),
      .svc_req(svc_req), .flag_clr(flag_clr), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .busy(busy), .done_flag(done_flag), .half_flag(half_flag),
      .irq(irq), .cur_src_addr(cur_src_addr), .cur_dst_addr(cur_dst_addr), .cur_iter(cur_iter));

   int nvec = 0;
   int nerr = 0;

   // bench-side descriptor
   logic [31:0] b_saddr, b_daddr, b_slast, b_dlast, b_minor;
   logic [15:0] b_sstep, b_dstep;
   logic [7:0]  b_sattr, b_dattr;
   logic        b_mode, b_hen, b_een;
   logic [15:0] b_biter;
   // model state
   logic [31:0] m_s, m_d;
   logic [15:0] m_citer;
   logic        m_done, m_half;

   function automatic logic [31:0] f_step(input logic [31:0] a, input logic [15:0] st, input logic [4:0] m);
      logic [31:0] sum, msk;
      sum = a + {{16{st[15]}}, st};
      msk = (m == 5'd0) ? 32'hFFFF_FFFF : ((32'd1 << m) - 32'd1);
      return (a & ~msk) | (sum & msk);
   endfunction

   function automatic logic [1:0] f_lg2(input logic [2:0] c);
      return (c >= 3'd2) ? 2'd2 : c[1:0];
   endfunction

   function automatic logic [1:0] f_sh(input logic [1:0] lo, input logic [1:0] lg2);
      return (lg2 == 2'd0) ? lo : (lg2 == 2'd1) ? {lo[1], 1'b0} : 2'd0;
   endfunction

   function automatic logic [3:0] f_be(input logic [1:0] lo, input logic [1:0] lg2);
      logic [3:0] b;
      b = (lg2 == 2'd0) ? 4'b0001 : (lg2 == 2'd1) ? 4'b0011 : 4'b1111;
      return b << f_sh(lo, lg2);
   endfunction

   function automatic logic [31:0] f_lanes(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [31:0] f_rdata(input logic [31:0] a);
      return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_1234;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic load_desc();
      cfg_src_addr = b_saddr; cfg_dst_addr = b_daddr;
      cfg_src_step = b_sstep; cfg_dst_step = b_dstep;
      cfg_src_attr = b_sattr; cfg_dst_attr = b_dattr;
      cfg_minor_word = b_minor; cfg_loop_ofs_mode = b_mode;
      cfg_src_end_adj = b_slast; cfg_dst_end_adj = b_dlast;
      cfg_iter_start = b_biter; cfg_half_irq_en = b_hen; cfg_end_irq_en = b_een;
      cfg_load = 1'b1; flag_clr = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0; flag_clr = 1'b0;
      m_s = b_saddr; m_d = b_daddr; m_citer = b_biter; m_done = 1'b0; m_half = 1'b0;
      chk(cur_iter == b_biter, "R6 count loaded", 32'(cur_iter), 32'(b_biter));
      chk(cur_src_addr == b_saddr, "R6 source loaded", cur_src_addr, b_saddr);
   endtask

   task automatic serve(input bit we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wexp, output logic [31:0] rd);
      logic [31:0] lm;
      while (!mem_req) @(negedge clk);
      chk(mem_we == we, "R3 read-then-write order", 32'(mem_we), 32'(we));
      chk(mem_addr == addr, we ? "R4/R5 destination address" : "R4/R5 source address", mem_addr, addr);
      chk(mem_be == be, "R2 byte enables", 32'(mem_be), 32'(be));
      if (we) begin
         lm = f_lanes(be);
         chk((mem_wdata & lm) == (wexp & lm), "R2 write lanes", mem_wdata & lm, wexp & lm);
      end
      repeat ($urandom % 3) @(negedge clk);
      rd = f_rdata(addr);
      mem_rdata = rd; mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
   endtask

   // mid: 0 none, 1 request during loop, 2 load attempt during loop
   task automatic run_minor(input bit do_req, input int mid, input bit clr_fin, input bit req_fin);
      logic [31:0] cnt, n, rd, val, mlx;
      logic [1:0]  ls, ld;
      logic        major, dset, hset;
      ls  = f_lg2(b_sattr[2:0]);
      ld  = f_lg2(b_dattr[2:0]);
      cnt = b_mode ? {22'd0, b_minor[9:0]} : b_minor;
      n   = cnt >> ls;
      if (do_req) begin
         svc_req = 1'b1;
         @(negedge clk);
         svc_req = 1'b0;
      end else if (n == 0) begin
         @(negedge clk);
      end
      if (mid == 1 && n > 0) begin
         svc_req = 1'b1;
         @(negedge clk);
         svc_req = 1'b0;
      end else if (mid == 2 && n > 0) begin
         cfg_src_addr = ~b_saddr; cfg_dst_addr = ~b_daddr; cfg_iter_start = b_biter + 16'd7;
         cfg_load = 1'b1;
         @(negedge clk);
         cfg_load = 1'b0;
      end
      for (int i = 0; i < int'(n); i++) begin
         serve(1'b0, m_s, f_be(m_s[1:0], ls), 32'd0, rd);
         val = (rd >> {f_sh(m_s[1:0], ls), 3'b000}) &
               ((ls == 2'd0) ? 32'hFF : (ls == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF);
         m_s = f_step(m_s, b_sstep, b_sattr[7:3]);
         serve(1'b1, m_d, f_be(m_d[1:0], ld), val << {f_sh(m_d[1:0], ld), 3'b000}, rd);
         m_d = f_step(m_d, b_dstep, b_dattr[7:3]);
      end
      // engine is now in its completion cycle
      flag_clr = clr_fin;
      svc_req  = req_fin;
      @(negedge clk);
      flag_clr = 1'b0;
      svc_req  = 1'b0;
      mlx   = {{12{b_minor[29]}}, b_minor[29:10]};
      major = (m_citer <= 16'd1);
      if (major) begin
         m_s = m_s + b_slast; m_d = m_d + b_dlast; m_citer = b_biter;
      end else begin
         m_citer = m_citer - 16'd1;
         if (b_mode && b_minor[31]) m_s = m_s + mlx;
         if (b_mode && b_minor[30]) m_d = m_d + mlx;
      end
      dset   = major;
      hset   = !major && (m_citer == (b_biter >> 1));
      m_done = dset || (m_done && !clr_fin);
      m_half = hset || (m_half && !clr_fin);
      chk(busy == 1'b0, "R3 loop ends", 32'(busy), 0);
      chk(cur_iter == m_citer, "R6 iteration count", 32'(cur_iter), 32'(m_citer));
      chk(cur_src_addr == m_s, "R6/R7 source after loop", cur_src_addr, m_s);
      chk(cur_dst_addr == m_d, "R6/R7 destination after loop", cur_dst_addr, m_d);
      chk(done_flag == m_done, "R6/R9 done flag", 32'(done_flag), 32'(m_done));
      chk(half_flag == m_half, "R8 half flag", 32'(half_flag), 32'(m_half));
      chk(irq == ((m_done && b_een) || (m_half && b_hen)), "R9 irq", 32'(irq),
          32'((m_done && b_een) || (m_half && b_hen)));
   endtask

   task automatic pulse_clr();
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      m_done = 1'b0; m_half = 1'b0;
      chk(done_flag == 1'b0 && half_flag == 1'b0, "R9 clear pulse", {done_flag, half_flag}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL R12 watchdog expired act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk(busy == 0 && mem_req == 0, "R1 reset idle", {busy, mem_req}, 0);
      chk(done_flag == 0 && half_flag == 0 && irq == 0, "R1 reset flags", {done_flag, half_flag, irq}, 0);
      chk(cur_iter == 0 && cur_src_addr == 0 && cur_dst_addr == 0, "R1 reset state", 32'(cur_iter), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8/R6: byte buffer to fixed register, half and done flags
      b_saddr = 32'h100; b_sstep = 16'd1; b_sattr = 8'h00;
      b_daddr = 32'h2003; b_dstep = 16'd0; b_dattr = 8'h00;
      b_minor = 32'd3; b_mode = 1'b0; b_slast = -32'sd12; b_dlast = 32'd0;
      b_biter = 16'd4; b_hen = 1'b1; b_een = 1'b1;
      load_desc();
      for (int k = 0; k < 4; k++) run_minor(1'b1, 0, 1'b0, 1'b0);

      // R5/R2/R11: 16-bit circular source, 32-bit destination, ignored load
      b_saddr = 32'h40E; b_sstep = 16'd2; b_sattr = {5'd4, 3'd1};
      b_daddr = 32'h800; b_dstep = 16'd4; b_dattr = 8'h02;
      b_minor = 32'd6; b_slast = 32'd0; b_dlast = -32'sd24; b_biter = 16'd2;
      load_desc();
      run_minor(1'b1, 2, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b0, 1'b0);

      // R7/R9: minor-loop offsets, same-cycle set and clear
      b_saddr = 32'h3000; b_sstep = 16'd4; b_sattr = 8'h02;
      b_daddr = 32'h5001; b_dstep = 16'd1; b_dattr = 8'h00;
      b_mode = 1'b1; b_minor = {1'b1, 1'b1, 20'hFFFF8, 10'd8};
      b_slast = 32'h100; b_dlast = -32'sd64; b_biter = 16'd3;
      load_desc();
      run_minor(1'b1, 0, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b1, 1'b0);
      chk(done_flag == 1'b1, "R9 set wins over clear", 32'(done_flag), 1);
      pulse_clr();

      // R3: partial element ignored, then zero-access loops
      b_mode = 1'b0; b_minor = 32'd5; b_saddr = 32'h6001; b_sattr = 8'h02; b_sstep = 16'hFFFC;
      b_daddr = 32'h7002; b_dattr = 8'h01; b_dstep = 16'd2; b_biter = 16'd2;
      load_desc();
      run_minor(1'b1, 0, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b0, 1'b0);
      b_minor = 32'd1; b_biter = 16'd3;
      load_desc();
      run_minor(1'b1, 0, 1'b0, 1'b1);
      run_minor(1'b0, 0, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b0, 1'b0);

      // R10: requests during a loop and in its completion cycle
      b_saddr = 32'h100; b_sstep = 16'd1; b_sattr = 8'h00;
      b_daddr = 32'h2003; b_dstep = 16'd0; b_dattr = 8'h00;
      b_minor = 32'd3; b_slast = -32'sd12; b_dlast = 32'd0; b_biter = 16'd4;
      load_desc();
      run_minor(1'b1, 1, 1'b0, 1'b0);
      run_minor(1'b0, 0, 1'b0, 1'b1);
      run_minor(1'b0, 0, 1'b0, 1'b0);
      run_minor(1'b1, 0, 1'b0, 1'b0);

      // random descriptors
      for (int t = 0; t < 40; t++) begin
         b_saddr = $urandom; b_daddr = $urandom;
         b_sstep = 16'($urandom_range(0, 128)) - 16'd64;
         b_dstep = 16'($urandom_range(0, 128)) - 16'd64;
         b_sattr = {(($urandom % 3) == 0) ? 5'd0 : 5'($urandom_range(2, 8)), 3'($urandom % 4)};
         b_dattr = {(($urandom % 3) == 0) ? 5'd0 : 5'($urandom_range(2, 8)), 3'($urandom % 4)};
         b_mode = 1'($urandom % 2);
         if (b_mode) b_minor = {1'($urandom % 2), 1'($urandom % 2), 20'($urandom), 10'($urandom_range(0, 16))};
         else        b_minor = 32'($urandom_range(0, 16));
         b_slast = $urandom; b_dlast = $urandom;
         b_biter = 16'($urandom_range(1, 5));
         b_hen = 1'($urandom % 2); b_een = 1'($urandom % 2);
         load_desc();
         for (int k = 0; k <= int'(b_biter); k++)
            run_minor(1'b1, 0, (($urandom % 4) == 0), 1'b0);
      end

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule